// File: doc/BRIEF.md
# Multi-Source System Reset Controller

This block merges five reset requests into one internal reset for a chip. The five requests are a power-on indication, an active-low external reset pin, a watchdog expiry pulse, a brown-out comparator level and a reset bit driven by a debug register. The watchdog request counts only while its enable is set. The brown-out request counts only while the detector enable is set. The external pin counts only after it has been low for a minimum number of clock cycles, which filters out short glitches.

The block has two reset outputs. The I/O reset follows the active sources through purely combinational logic, so it asserts with no clock edge. The core reset covers everything the I/O reset covers, and it stays asserted for a selectable number of clock cycles after the last source has gone inactive. That extra time lets supplies and clocks settle before normal operation starts.

A sticky set of cause flags records which sources have caused a reset. Software clears the flags one at a time by writing ones to them.

Top module: `sysrst_merge`

## Requirements
- R1: `io_rst_o` is high, with no clock edge needed, whenever any gated source is active. The gated sources are `por_i`; the qualified external pin; `wdt_expire_i` together with `wdt_en_i`; `bod_low_i` together with `bod_en_i`; and `dbg_rst_i`.
- R2: The external pin becomes a qualified source only after it has been sampled low on 4 consecutive rising clock edges. A low of 3 or fewer sampled cycles changes neither the outputs nor the flags.
- R3: Once the pin is qualified, the external request ends as soon as the pin returns high, without waiting for a clock edge.
- R4: A watchdog expiry with `wdt_en_i` low has no effect on the outputs or the flags. With `wdt_en_i` high, the expiry asserts reset.
- R5: A brown-out level with `bod_en_i` low has no effect. With `bod_en_i` high, the brown-out level asserts reset.
- R6: The core reset stays high for as long as `dbg_rst_i` is one.
- R7: The first rising edge at which every source is sampled inactive is the start edge. At the start edge, `dly_sel_i` is sampled: code 0 gives N = 0, code 1 gives N = 16, code 2 gives N = 256 and code 3 gives N = 4096. `core_rst_o` falls right after the N-th edge following the start edge. A change of `dly_sel_i` after the start edge has no effect.
- R8: If any source asserts again while the delay is counting, the count is abandoned. A fresh full delay then starts after all sources are inactive again.
- R9: `cause_o` bit 0 is power-on, bit 1 is external, bit 2 is watchdog, bit 3 is brown-out and bit 4 is debug. A bit is set at every rising edge at which its source is active. Power-on sets the value 5'b00001 and clears every other flag.
- R10: A one in bit k of `flag_clr_i` clears `cause_o[k]` at the next rising edge. If the source of that flag is active at the same edge, the set wins.
- R11: `core_rst_o` is high whenever `io_rst_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pin filter, the delay counter and the cause flags |
| por_i | input | 1 | Power-on indication, active high; asynchronously clears all state |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| wdt_expire_i | input | 1 | Watchdog expiry pulse |
| wdt_en_i | input | 1 | Watchdog reset enable |
| bod_low_i | input | 1 | Brown-out comparator: supply is low |
| bod_en_i | input | 1 | Brown-out detector enable |
| dbg_rst_i | input | 1 | Debug-register reset bit |
| dly_sel_i | input | 2 | Release delay code (0, 16, 256 or 4096 cycles) |
| flag_clr_i | input | 5 | Write-one-to-clear strobes for the cause flags |
| io_rst_o | output | 1 | Asynchronous I/O reset |
| core_rst_o | output | 1 | Stretched core reset |
| cause_o | output | 5 | Sticky reset-cause flags |

## Verification
The bench drives a 3-cycle pin glitch and then a 4-cycle low. A filter that counted off by one would either reset on the glitch or miss the valid pulse. It measures the release edge for codes 0, 16 and 4096. It also changes the code just after the count has started: a design that resampled the code late, or counted one edge too many or too few, would release on the wrong cycle. It re-asserts a source in the middle of a 256-cycle count, where a controller that kept counting would release early. It pulses the watchdog and the brown-out with their enables off, clears the debug flag while the debug source is still active, and applies power-on over set flags; a wrong gating or wrong clear priority shows up directly in the flags.

// File: rtl/sysrst_pkg.sv
package sysrst_pkg;

    localparam int NUM_SRC = 5;

    // Bit positions of each source in the cause vector.
    typedef struct packed {
        logic dbg;   // bit 4
        logic bod;   // bit 3
        logic wdt;   // bit 2
        logic ext;   // bit 1
        logic por;   // bit 0
    } src_vec_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_COUNT = 2'd2
    } hold_st_e;

    // Delay length for a select code: 0, then 2^(step*code).
    function automatic int unsigned dly_cycles(input logic [1:0] code,
                                               input int unsigned step);
        if (code == 2'd0)
            return 0;
        return 32'd1 << (step * int'(code));
    endfunction

endpackage

// File: rtl/sysrst_pin_filter.sv
module sysrst_pin_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic por_i,
    input  logic pin_n_i,
    output logic qual_o
);
    localparam int W = $clog2(FILT_LEN + 1);
    localparam logic [W-1:0] FULL = W'(FILT_LEN);

    logic [W-1:0] run_q;

    // Count consecutive low samples, saturating once the length is reached.
    always_ff @(posedge clk or posedge por_i) begin
        if (por_i)
            run_q <= '0;
        else if (pin_n_i)
            run_q <= '0;
        else if (run_q != FULL)
            run_q <= run_q + 1'b1;
    end

    // Once qualified, the request ends the moment the pin goes high.
    assign qual_o = (run_q == FULL) & ~pin_n_i;

endmodule

// File: rtl/sysrst_stretch.sv
module sysrst_stretch
    import sysrst_pkg::*;
#(
    parameter int DLY_STEP = 4,
    parameter int CNT_W    = 13
) (
    input  logic       clk,
    input  logic       por_i,
    input  logic       src_any_i,
    input  logic [1:0] dly_sel_i,
    output logic       hold_o
);
    hold_st_e           st_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   lim_q;
    logic [CNT_W-1:0]   sel_len;

    assign sel_len = CNT_W'(dly_cycles(dly_sel_i, DLY_STEP));

    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            st_q  <= ST_HOLD;
            cnt_q <= '0;
            lim_q <= '0;
        end else if (src_any_i) begin
            st_q  <= ST_HOLD;
            cnt_q <= '0;
        end else begin
            case (st_q)
                ST_HOLD: begin
                    lim_q <= sel_len;
                    cnt_q <= '0;
                    st_q  <= (sel_len == '0) ? ST_IDLE : ST_COUNT;
                end
                ST_COUNT: begin
                    if (cnt_q == lim_q - 1'b1)
                        st_q <= ST_IDLE;
                    else
                        cnt_q <= cnt_q + 1'b1;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign hold_o = (st_q != ST_IDLE);

endmodule

// File: rtl/sysrst_cause.sv
module sysrst_cause
    import sysrst_pkg::*;
(
    input  logic               clk,
    input  logic               por_i,
    input  logic [NUM_SRC-1:0] set_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] flags_o
);
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_flag
        localparam logic RST_VAL = (k == 0);
        logic f_q;
        always_ff @(posedge clk or posedge por_i) begin
            if (por_i)
                f_q <= RST_VAL;
            else if (set_i[k])
                f_q <= 1'b1;
            else if (clr_i[k])
                f_q <= 1'b0;
        end
        assign flags_o[k] = f_q;
    end

endmodule

// File: rtl/sysrst_merge.sv
module sysrst_merge
    import sysrst_pkg::*;
#(
    parameter int FILT_LEN = 4,
    parameter int DLY_STEP = 4,
    parameter int CNT_W    = 13
) (
    input  logic               clk,
    input  logic               por_i,
    input  logic               ext_rst_n_i,
    input  logic               wdt_expire_i,
    input  logic               wdt_en_i,
    input  logic               bod_low_i,
    input  logic               bod_en_i,
    input  logic               dbg_rst_i,
    input  logic [1:0]         dly_sel_i,
    input  logic [NUM_SRC-1:0] flag_clr_i,
    output logic               io_rst_o,
    output logic               core_rst_o,
    output logic [NUM_SRC-1:0] cause_o
);
    src_vec_t act;
    logic     ext_qual;
    logic     hold;

    sysrst_pin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk     (clk),
        .por_i   (por_i),
        .pin_n_i (ext_rst_n_i),
        .qual_o  (ext_qual)
    );

    always_comb begin
        act.por = por_i;
        act.ext = ext_qual;
        act.wdt = wdt_expire_i & wdt_en_i;
        act.bod = bod_low_i & bod_en_i;
        act.dbg = dbg_rst_i;
    end

    assign io_rst_o = |act;

    sysrst_stretch #(.DLY_STEP(DLY_STEP), .CNT_W(CNT_W)) u_stretch (
        .clk       (clk),
        .por_i     (por_i),
        .src_any_i (io_rst_o),
        .dly_sel_i (dly_sel_i),
        .hold_o    (hold)
    );

    assign core_rst_o = io_rst_o | hold;

    sysrst_cause u_cause (
        .clk     (clk),
        .por_i   (por_i),
        .set_i   (act),
        .clr_i   (flag_clr_i),
        .flags_o (cause_o)
    );

endmodule

// File: rtl/sysrst_merge_chk.sv
module sysrst_merge_chk
    import sysrst_pkg::*;
#(
    parameter int FILT_LEN = 4,
    parameter int DLY_STEP = 4,
    parameter int CNT_W    = 13
) (
    input logic               clk,
    input logic               por_i,
    input logic               ext_rst_n_i,
    input logic               wdt_expire_i,
    input logic               wdt_en_i,
    input logic               bod_low_i,
    input logic               bod_en_i,
    input logic               dbg_rst_i,
    input logic [1:0]         dly_sel_i,
    input logic [NUM_SRC-1:0] flag_clr_i,
    input logic               io_rst_o,
    input logic               core_rst_o,
    input logic [NUM_SRC-1:0] cause_o
);
    localparam int QW = CNT_W + 1;
    logic [QW-1:0] quiet_q;
    logic [1:0]    sel_q;

    // Cycles since the I/O reset was last sampled high; code kept at start.
    always_ff @(posedge clk or posedge por_i) begin
        if (por_i) begin
            quiet_q <= '0;
            sel_q   <= '0;
        end else if (io_rst_o) begin
            quiet_q <= '0;
        end else begin
            if (quiet_q == '0)
                sel_q <= dly_sel_i;
            if (quiet_q != {QW{1'b1}})
                quiet_q <= quiet_q + 1'b1;
        end
    end

    // R7 R8
    release_delay_chk: assert property (@(posedge clk) disable iff (por_i)
        $fell(core_rst_o) |-> (quiet_q == QW'(dly_cycles(sel_q, DLY_STEP)) + 1'b1));

    // R2
    ext_filter_chk: assert property (@(posedge clk) disable iff (por_i)
        $rose(cause_o[1]) |-> (!$past(ext_rst_n_i, 1) && !$past(ext_rst_n_i, 2)
                               && !$past(ext_rst_n_i, 3) && !$past(ext_rst_n_i, 4)));

    // R4
    wdt_gate_chk: assert property (@(posedge clk) disable iff (por_i)
        $rose(cause_o[2]) |-> $past(wdt_expire_i && wdt_en_i));

    // R5
    bod_gate_chk: assert property (@(posedge clk) disable iff (por_i)
        $rose(cause_o[3]) |-> $past(bod_low_i && bod_en_i));

    // R6
    dbg_hold_chk: assert property (@(posedge clk) disable iff (por_i)
        dbg_rst_i |-> core_rst_o);

    // R10
    w1c_chk: assert property (@(posedge clk) disable iff (por_i)
        $past(flag_clr_i[4] && !dbg_rst_i) |-> !cause_o[4]);

    // R11
    core_cover_chk: assert property (@(posedge clk) disable iff (por_i)
        io_rst_o |-> core_rst_o);

endmodule

bind sysrst_merge sysrst_merge_chk #(
    .FILT_LEN(FILT_LEN), .DLY_STEP(DLY_STEP), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .por_i(por_i), .ext_rst_n_i(ext_rst_n_i),
    .wdt_expire_i(wdt_expire_i), .wdt_en_i(wdt_en_i),
    .bod_low_i(bod_low_i), .bod_en_i(bod_en_i), .dbg_rst_i(dbg_rst_i),
    .dly_sel_i(dly_sel_i), .flag_clr_i(flag_clr_i),
    .io_rst_o(io_rst_o), .core_rst_o(core_rst_o), .cause_o(cause_o)
);

// File: tb/tb_sysrst_merge.sv
`timescale 1ns/1ps
module tb_sysrst_merge;

    logic       clk = 1'b0;
    logic       por_i = 1'b1;
    logic       ext_rst_n_i = 1'b1;
    logic       wdt_expire_i = 1'b0;
    logic       wdt_en_i = 1'b0;
    logic       bod_low_i = 1'b0;
    logic       bod_en_i = 1'b0;
    logic       dbg_rst_i = 1'b0;
    logic [1:0] dly_sel_i = 2'd1;
    logic [4:0] flag_clr_i = 5'd0;
    logic       io_rst_o;
    logic       core_rst_o;
    logic [4:0] cause_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sysrst_merge dut (
        .clk(clk), .por_i(por_i), .ext_rst_n_i(ext_rst_n_i),
        .wdt_expire_i(wdt_expire_i), .wdt_en_i(wdt_en_i),
        .bod_low_i(bod_low_i), .bod_en_i(bod_en_i), .dbg_rst_i(dbg_rst_i),
        .dly_sel_i(dly_sel_i), .flag_clr_i(flag_clr_i),
        .io_rst_o(io_rst_o), .core_rst_o(core_rst_o), .cause_o(cause_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model
    int       m_low = 0;
    int       m_st = 1;        // 0 released, 1 waiting, 2 counting
    int       m_cnt = 0;
    int       m_lim = 0;
    logic [4:0] m_flags = 5'b00001;

    function automatic int sel_to_len(input logic [1:0] s);
        case (s)
            2'd0: return 0;
            2'd1: return 16;
            2'd2: return 256;
            default: return 4096;
        endcase
    endfunction

    function automatic bit m_ext();
        return (m_low >= 4) && !ext_rst_n_i;
    endfunction

    always @(posedge clk) begin
        if (por_i) begin
            m_low = 0; m_st = 1; m_cnt = 0; m_flags = 5'b00001;
        end else begin
            bit e, w, b, d, any;
            e = m_ext();
            w = wdt_expire_i && wdt_en_i;
            b = bod_low_i && bod_en_i;
            d = dbg_rst_i;
            any = e || w || b || d;
            m_flags = (m_flags & ~flag_clr_i) | {d, b, w, e, 1'b0};
            if (ext_rst_n_i) m_low = 0;
            else if (m_low < 4) m_low++;
            if (any) begin
                m_st = 1; m_cnt = 0;
            end else if (m_st == 1) begin
                m_lim = sel_to_len(dly_sel_i);
                m_cnt = 0;
                m_st = (m_lim == 0) ? 0 : 2;
            end else if (m_st == 2) begin
                if (m_cnt == m_lim - 1) m_st = 0;
                else m_cnt++;
            end
        end
        #1;
        begin
            bit io_e;
            io_e = por_i || m_ext() || (wdt_expire_i && wdt_en_i) ||
                   (bod_low_i && bod_en_i) || dbg_rst_i;
            chk("R1 io_rst_o", int'(io_rst_o), int'(io_e));
            chk("R7 core_rst_o", int'(core_rst_o), int'(io_e || (m_st != 0)));
            chk("R9 cause_o", int'(cause_o), int'(m_flags));
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        // Power-on with the 16-cycle code
        step(3);
        chk("R9 reset cause", int'(cause_o), 1);
        chk("R11 reset core", int'(core_rst_o), 1);
        por_i = 1'b0;
        step(16);
        chk("R7 code1 held", int'(core_rst_o), 1);
        step(1);
        chk("R7 code1 released", int'(core_rst_o), 0);

        // Clear power-on flag
        flag_clr_i = 5'b00001; step(1); flag_clr_i = 5'd0;
        chk("R10 clear por flag", int'(cause_o), 0);

        // Pin glitch of 3 cycles
        dly_sel_i = 2'd0;
        ext_rst_n_i = 1'b0; step(3);
        ext_rst_n_i = 1'b1; #1;
        chk("R2 glitch io", int'(io_rst_o), 0);
        step(2);
        chk("R2 glitch flag", int'(cause_o[1]), 0);
        chk("R2 glitch core", int'(core_rst_o), 0);

        // Qualified pin low
        ext_rst_n_i = 1'b0; step(3);
        chk("R2 three lows", int'(io_rst_o), 0);
        step(1);
        chk("R2 four lows", int'(io_rst_o), 1);
        step(2);
        ext_rst_n_i = 1'b1; #1;
        chk("R3 pin release io", int'(io_rst_o), 0);
        chk("R11 core still held", int'(core_rst_o), 1);
        chk("R9 ext flag", int'(cause_o[1]), 1);
        step(1);
        chk("R7 code0 release", int'(core_rst_o), 0);

        // Watchdog disabled then enabled
        wdt_expire_i = 1'b1; step(1); wdt_expire_i = 1'b0; step(1);
        chk("R4 wdt gated flag", int'(cause_o[2]), 0);
        chk("R4 wdt gated core", int'(core_rst_o), 0);
        wdt_en_i = 1'b1; wdt_expire_i = 1'b1; #1;
        chk("R1 wdt async io", int'(io_rst_o), 1);
        step(1); wdt_expire_i = 1'b0;
        chk("R4 wdt flag", int'(cause_o[2]), 1);
        chk("R4 wdt core", int'(core_rst_o), 1);
        step(1);
        chk("R4 wdt release", int'(core_rst_o), 0);

        // Brown-out disabled then enabled
        bod_low_i = 1'b1; step(3);
        chk("R5 bod gated io", int'(io_rst_o), 0);
        chk("R5 bod gated flag", int'(cause_o[3]), 0);
        bod_en_i = 1'b1; #1;
        chk("R5 bod io", int'(io_rst_o), 1);
        step(2);
        chk("R5 bod flag", int'(cause_o[3]), 1);
        bod_low_i = 1'b0; step(2);

        // Debug reset with set-wins clear
        dbg_rst_i = 1'b1; #1;
        chk("R1 dbg async io", int'(io_rst_o), 1);
        step(1);
        flag_clr_i = 5'b10000; step(1); flag_clr_i = 5'd0;
        chk("R10 set wins", int'(cause_o[4]), 1);
        step(8);
        chk("R6 dbg held", int'(core_rst_o), 1);
        dbg_rst_i = 1'b0;
        flag_clr_i = 5'b10000; step(1); flag_clr_i = 5'd0;
        chk("R10 dbg cleared", int'(cause_o[4]), 0);
        chk("R10 other flag kept", int'(cause_o[3]), 1);

        // Code changed after start edge
        dbg_rst_i = 1'b1; dly_sel_i = 2'd1; step(2);
        dbg_rst_i = 1'b0; step(1);
        dly_sel_i = 2'd3; step(15);
        chk("R7 late code held", int'(core_rst_o), 1);
        step(1);
        chk("R7 late code ignored", int'(core_rst_o), 0);

        // Restart during 256 count
        dbg_rst_i = 1'b1; dly_sel_i = 2'd2; step(2);
        dbg_rst_i = 1'b0; step(100);
        dbg_rst_i = 1'b1; step(1);
        dbg_rst_i = 1'b0; step(256);
        chk("R8 restarted held", int'(core_rst_o), 1);
        step(1);
        chk("R8 restarted release", int'(core_rst_o), 0);

        // Longest delay
        dbg_rst_i = 1'b1; dly_sel_i = 2'd3; step(2);
        dbg_rst_i = 1'b0; step(4096);
        chk("R7 code3 held", int'(core_rst_o), 1);
        step(1);
        chk("R7 code3 released", int'(core_rst_o), 0);

        // Power-on over set flags
        dly_sel_i = 2'd0;
        por_i = 1'b1; #1;
        chk("R1 por async io", int'(io_rst_o), 1);
        step(2);
        chk("R9 por clears flags", int'(cause_o), 1);
        por_i = 1'b0; step(2);
        chk("R7 por release", int'(core_rst_o), 0);

        done = 1;
        finish_run();
    end

endmodule